// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Condition Flags

This block is the data path of a small eight-bit processor. Each cycle it takes an operation code, two byte operands (`a_i`, the accumulator side, and `b_i`, the source side), the current carry and half-carry. In the same cycle it returns the result byte, a high byte for the two operations that produce sixteen bits, a result write-enable, a proposed flag byte and a per-flag update mask. Every operation has its own rule for which flags it changes and how.

A condition register inside the block takes those flags when `cap_i` is high on a clock edge. Only the bits set in the update mask change. The other bits keep their value. The flag byte uses a fixed layout: half-carry in bit 5, negative in bit 3, zero in bit 2, overflow in bit 1 and carry in bit 0. Bits 7, 6 and 4 are always zero.

Top module: `alu8_flagged_core`

## Requirements
- R1: ADD (code 0) gives a+b, and ADC (code 1) gives a+b+carry. Both set H (carry out of bit 3), N (result bit 7), Z (result zero), V (signed overflow) and C (carry out of bit 7). The mask is 0x2F.
- R2: SUB (code 2) gives a-b, and SBC (code 3) gives a-b-carry. CMP (code 4) works like SUB but holds the write-enable low. All three update N, Z and V, and set C when a borrow occurs. The mask is 0x0F and H is left unchanged.
- R3: AND (5), OR (6), XOR (7), BIT (8, the AND of a and b), LD (9, passes b) and TST (10, passes a) update N and Z and force V to 0. Carry is not in their mask (mask 0x0E). BIT and TST hold the write-enable low.
- R4: CLR (11) gives 0 with N=0, Z=1, V=0 and C=0. COM (12) gives the bitwise complement of a with V=0 and C=1. Both use mask 0x0F.
- R5: NEG (13) gives 0-a. V is set only for a=0x80, and C is set when a is nonzero (mask 0x0F). INC (14) and DEC (15) add or subtract one. They set V for 0x7F and 0x80 respectively, and leave C out of the mask (mask 0x0E).
- R6: ASL (16) shifts a left with C taken from a bit 7 and V set to N XOR C of the result (mask 0x0F). ASR (17) shifts right and keeps bit 7. LSR (18) shifts in a zero, so N is 0. ASR and LSR take C from a bit 0 and use mask 0x0D.
- R7: ROL (19) shifts the carry into bit 0 and bit 7 into C, with V set to N XOR C (mask 0x0F). ROR (20) shifts the carry into bit 7 and bit 0 into C (mask 0x0D).
- R8: DAA (21) adds 0x06 when the low nibble of a is above 9 or H is set. It adds 0x60 when the high nibble is above 9, or C is set, or the high nibble is 9 and the low nibble is above 9. C becomes the old C OR the carry of that addition. The mask is 0x0D.
- R9: SEX (22) returns b as the low byte and copies b bit 7 into all of the high byte. N and Z describe the sixteen-bit value (mask 0x0C).
- R10: MUL (23) returns the unsigned product a*b, with the low byte in the result and the high byte in `res_hi_o`. Z shows a zero product and C equals bit 7 of the low byte. The mask is 0x05.
- R11: The condition register is zero after reset. On an edge with `cap_i` high, each bit in the mask takes the proposed value and every other bit is held. With `cap_i` low the register does not change.
- R12: Codes 24 to 31 have no effect. They give a zero mask, a low write-enable, a zero result and a zero high byte. For every operation except SEX and MUL the high byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator-side operand |
| b_i | input | 8 | Source-side operand |
| c_i | input | 1 | Current carry |
| h_i | input | 1 | Current half-carry |
| cap_i | input | 1 | Capture strobe for the condition register |
| res_o | output | 8 | Result byte |
| res_hi_o | output | 8 | High byte for SEX and MUL, zero otherwise |
| wr_o | output | 1 | Result write-enable |
| fval_o | output | 8 | Proposed flag values |
| fmask_o | output | 8 | Flags updated by this operation |
| cc_o | output | 8 | Condition register |

## Verification
Each operation is driven with its edge operands: values that cross the signed boundary 0x7F/0x80, values that wrap at 0xFF/0x00, and values that carry out of the low nibble. This separates the overflow, carry and half-carry rules from one another, and separates borrow from carry. DAA is tried on inputs that need only the low correction, only the high correction, both, and neither, and with H or C arriving already set. MUL is tried with zero, single-byte and full-width products. The capture strobe is toggled so that a held register can be told apart from one that takes unmasked bits. A long pseudo-random run over all operations and carry states follows.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int OPW   = 5;
    localparam int FW    = 8;
    localparam int N_OPS = 24;

    localparam int FB_H = 5;
    localparam int FB_N = 3;
    localparam int FB_Z = 2;
    localparam int FB_V = 1;
    localparam int FB_C = 0;

    localparam logic [FW-1:0] MK_HNZVC = FW'((1 << FB_H) | (1 << FB_N) | (1 << FB_Z) | (1 << FB_V) | (1 << FB_C));
    localparam logic [FW-1:0] MK_NZVC  = FW'((1 << FB_N) | (1 << FB_Z) | (1 << FB_V) | (1 << FB_C));
    localparam logic [FW-1:0] MK_NZV   = FW'((1 << FB_N) | (1 << FB_Z) | (1 << FB_V));
    localparam logic [FW-1:0] MK_NZC   = FW'((1 << FB_N) | (1 << FB_Z) | (1 << FB_C));
    localparam logic [FW-1:0] MK_NZ    = FW'((1 << FB_N) | (1 << FB_Z));
    localparam logic [FW-1:0] MK_ZC    = FW'((1 << FB_Z) | (1 << FB_C));

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_EOR = 5'd7,
        OP_BIT = 5'd8,  OP_LD  = 5'd9,  OP_TST = 5'd10, OP_CLR = 5'd11,
        OP_COM = 5'd12, OP_NEG = 5'd13, OP_INC = 5'd14, OP_DEC = 5'd15,
        OP_ASL = 5'd16, OP_ASR = 5'd17, OP_LSR = 5'd18, OP_ROL = 5'd19,
        OP_ROR = 5'd20, OP_DAA = 5'd21, OP_SEX = 5'd22, OP_MUL = 5'd23
    } op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] hi;
        logic [FW-1:0] fv;
        logic [FW-1:0] fm;
        logic          we;
    } alu_out_t;

    function automatic logic [FW-1:0] nz_flags(input logic [DW-1:0] r);
        logic [FW-1:0] f;
        f       = '0;
        f[FB_N] = r[DW-1];
        f[FB_Z] = (r == '0);
        return f;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output alu_out_t      o,
    output logic          hit
);
    logic [DW-1:0] x, y;
    logic          ci, sub;
    logic [DW:0]   sum;

    always_comb begin
        x = a; y = b; ci = 1'b0; sub = 1'b0; hit = 1'b1;
        unique case (op)
            OP_ADD: ;
            OP_ADC: ci = cin;
            OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; sub = 1'b1; end
            OP_SBC: begin y = ~b; ci = ~cin; sub = 1'b1; end
            OP_NEG: begin x = '0; y = ~a; ci = 1'b1; sub = 1'b1; end
            OP_INC: begin y = '0; ci = 1'b1; end
            OP_DEC: y = '1;
            default: hit = 1'b0;
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};

    always_comb begin
        o       = '0;
        o.res   = sum[DW-1:0];
        o.we    = hit && (op != OP_CMP);
        o.fv    = nz_flags(sum[DW-1:0]);
        o.fv[FB_V] = (x[DW-1] == y[DW-1]) && (sum[DW-1] != x[DW-1]);
        o.fv[FB_C] = sub ? ~sum[DW] : sum[DW];
        o.fv[FB_H] = x[4] ^ y[4] ^ sum[4];
        case (op)
            OP_ADD, OP_ADC: o.fm = MK_HNZVC;
            OP_INC, OP_DEC: o.fm = MK_NZV;
            default:        o.fm = hit ? MK_NZVC : '0;
        endcase
        if (!hit) o = '0;
    end

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CMP) |-> (!o.we && o.fm == MK_NZVC)); // R2
    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUB) |-> (o.fv[FB_C] == (a < b))); // R2
    AST_INC_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC || op == OP_DEC) |-> !o.fm[FB_C]); // R5

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output alu_out_t      o,
    output logic          hit
);
    logic [DW-1:0] r;
    logic          cy, logic_op, left;

    always_comb begin
        r = '0; cy = 1'b0; hit = 1'b1; logic_op = 1'b0; left = 1'b0;
        unique case (op)
            OP_AND, OP_BIT: begin r = a & b; logic_op = 1'b1; end
            OP_OR:          begin r = a | b; logic_op = 1'b1; end
            OP_EOR:         begin r = a ^ b; logic_op = 1'b1; end
            OP_LD:          begin r = b;     logic_op = 1'b1; end
            OP_TST:         begin r = a;     logic_op = 1'b1; end
            OP_CLR:         r = '0;
            OP_COM:         begin r = ~a; cy = 1'b1; end
            OP_ASL:         begin r = {a[DW-2:0], 1'b0}; cy = a[DW-1]; left = 1'b1; end
            OP_ROL:         begin r = {a[DW-2:0], cin};  cy = a[DW-1]; left = 1'b1; end
            OP_ASR:         begin r = {a[DW-1], a[DW-1:1]}; cy = a[0]; end
            OP_LSR:         begin r = {1'b0, a[DW-1:1]};    cy = a[0]; end
            OP_ROR:         begin r = {cin, a[DW-1:1]};     cy = a[0]; end
            default:        hit = 1'b0;
        endcase
    end

    always_comb begin
        o          = '0;
        o.res      = r;
        o.we       = hit && (op != OP_BIT) && (op != OP_TST);
        o.fv       = nz_flags(r);
        o.fv[FB_C] = cy;
        o.fv[FB_V] = left && (r[DW-1] ^ cy);
        if (logic_op)                                         o.fm = MK_NZV;
        else if (op == OP_ASR || op == OP_LSR || op == OP_ROR) o.fm = MK_NZC;
        else                                                  o.fm = MK_NZVC;
        if (!hit) o = '0;
    end

    AST_LOGIC_KEEP_C: assert property (@(posedge clk) disable iff (rst)
        (op inside {OP_AND, OP_OR, OP_EOR, OP_BIT, OP_LD, OP_TST})
        |-> (!o.fm[FB_C] && o.fm[FB_V] && !o.fv[FB_V])); // R3
    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR) |-> (o.res == '0 && o.fv[FB_Z] && !o.fv[FB_N] && !o.fv[FB_C])); // R4
    AST_LSR_POSITIVE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LSR) |-> (!o.fv[FB_N] && o.fm[FB_N])); // R6

endmodule

// File: rtl/alu8_wide.sv
module alu8_wide
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          hin,
    output alu_out_t      o,
    output logic          hit
);
    localparam int NW = DW / 2;

    logic [NW-1:0]   lo_nib, hi_nib;
    logic            fix_lo, fix_hi;
    logic [DW:0]     dsum;
    logic [2*DW-1:0] prod;

    assign lo_nib = a[NW-1:0];
    assign hi_nib = a[DW-1:NW];
    assign fix_lo = (lo_nib > NW'(9)) || hin;
    assign fix_hi = (hi_nib > NW'(9)) || cin || ((hi_nib == NW'(9)) && (lo_nib > NW'(9)));
    assign dsum   = {1'b0, a} + {1'b0, (fix_hi ? NW'(6) : NW'(0)), (fix_lo ? NW'(6) : NW'(0))};
    assign prod   = a * b;

    always_comb begin
        o   = '0;
        hit = 1'b1;
        unique case (op)
            OP_DAA: begin
                o.res = dsum[DW-1:0];
                o.fv  = nz_flags(dsum[DW-1:0]);
                o.fv[FB_C] = cin | dsum[DW];
                o.fm  = MK_NZC;
                o.we  = 1'b1;
            end
            OP_SEX: begin
                o.res = b;
                o.hi  = {DW{b[DW-1]}};
                o.fv  = nz_flags(b);
                o.fm  = MK_NZ;
                o.we  = 1'b1;
            end
            OP_MUL: begin
                o.res = prod[DW-1:0];
                o.hi  = prod[2*DW-1:DW];
                o.fv[FB_Z] = (prod == '0);
                o.fv[FB_C] = prod[DW-1];
                o.fm  = MK_ZC;
                o.we  = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

    AST_MUL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MUL && (a == '0 || b == '0)) |-> (o.fv[FB_Z] && !o.fv[FB_C])); // R10
    AST_SEX_HIGH: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEX) |-> (o.hi == '0 || o.hi == '1)); // R9
    AST_DAA_KEEP_C: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DAA && cin) |-> o.fv[FB_C]); // R8

endmodule

// File: rtl/alu8_flagged_core.sv
module alu8_flagged_core
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic           c_i,
    input  logic           h_i,
    input  logic           cap_i,
    output logic [DW-1:0]  res_o,
    output logic [DW-1:0]  res_hi_o,
    output logic           wr_o,
    output logic [FW-1:0]  fval_o,
    output logic [FW-1:0]  fmask_o,
    output logic [FW-1:0]  cc_o
);
    localparam int NU = 3;

    op_e           op;
    alu_out_t      src [NU];
    logic [NU-1:0] hit;
    alu_out_t      sel;
    logic [FW-1:0] cc_q;

    assign op = op_e'(op_i);

    alu8_addsub u_addsub (.clk(clk), .rst(rst), .op(op), .a(a_i), .b(b_i), .cin(c_i),
                          .o(src[0]), .hit(hit[0]));
    alu8_bitops u_bitops (.clk(clk), .rst(rst), .op(op), .a(a_i), .b(b_i), .cin(c_i),
                          .o(src[1]), .hit(hit[1]));
    alu8_wide   u_wide   (.clk(clk), .rst(rst), .op(op), .a(a_i), .b(b_i), .cin(c_i),
                          .hin(h_i), .o(src[2]), .hit(hit[2]));

    always_comb begin
        sel = '0;
        for (int i = 0; i < NU; i++) begin
            if (hit[i]) sel = src[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        cc_q <= '0;
        else if (cap_i) cc_q <= (cc_q & ~sel.fm) | (sel.fv & sel.fm);
    end

    assign res_o    = sel.res;
    assign res_hi_o = sel.hi;
    assign wr_o     = sel.we;
    assign fval_o   = sel.fv;
    assign fmask_o  = sel.fm;
    assign cc_o     = cc_q;

    AST_ONE_UNIT: assert property (@(posedge clk) disable iff (rst)
        $countones(hit) <= 1); // R12
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_i >= OPW'(N_OPS)) |-> (!wr_o && fmask_o == '0 && res_hi_o == '0)); // R12
    AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(cc_o)); // R11
    AST_CC_TAKE: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> ((cc_o & $past(fmask_o)) == ($past(fval_o) & $past(fmask_o)))); // R11
    AST_CC_KEEP: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> ((cc_o & ~$past(fmask_o)) == ($past(cc_o) & ~$past(fmask_o)))); // R11

endmodule

// File: tb/alu8_flagged_core_bench.sv
module alu8_flagged_core_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0;
    logic       c_i = 1'b0, h_i = 1'b0, cap_i = 1'b0;
    logic [7:0] res_o, res_hi_o, fval_o, fmask_o, cc_o;
    logic       wr_o;

    alu8_flagged_core u_alu8_flagged_core (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .h_i(h_i),
        .cap_i(cap_i), .res_o(res_o), .res_hi_o(res_hi_o), .wr_o(wr_o), .fval_o(fval_o),
        .fmask_o(fmask_o), .cc_o(cc_o));

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    res, hi, fv, fm, we, cc;
        string tag;
    } item_t;

    item_t sbq[$];
    int    checks = 0, fails = 0, cc_model = 0;
    bit    done = 0;
    int    seed = 32'h1234_5678;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic string tag_of(int op);
        if (op <= 1)  return "R1";
        if (op <= 4)  return "R2";
        if (op <= 10) return "R3";
        if (op <= 12) return "R4";
        if (op <= 15) return "R5";
        if (op <= 18) return "R6";
        if (op <= 20) return "R7";
        if (op == 21) return "R8";
        if (op == 22) return "R9";
        if (op == 23) return "R10";
        return "R12";
    endfunction

    function automatic item_t model(int op, int a, int b, int c, int h);
        item_t e;
        int s, r, hi, C, V, H, add, p;
        r = 0; hi = 0; C = 0; V = 0; H = 0;
        e.we = 1; e.fm = 0;
        case (op)
            0, 1: begin
                s = a + b + ((op == 1) ? c : 0);
                r = s & 255; C = (s > 255);
                H = ((a & 15) + (b & 15) + ((op == 1) ? c : 0)) > 15;
                s = sx(a) + sx(b) + ((op == 1) ? c : 0);
                V = (s > 127 || s < -128); e.fm = 'h2F;
            end
            2, 3, 4: begin
                s = a - b - ((op == 3) ? c : 0);
                r = s & 255; C = (s < 0);
                s = sx(a) - sx(b) - ((op == 3) ? c : 0);
                V = (s > 127 || s < -128); e.fm = 'h0F; e.we = (op != 4);
            end
            5:  begin r = a & b; e.fm = 'h0E; end
            6:  begin r = a | b; e.fm = 'h0E; end
            7:  begin r = a ^ b; e.fm = 'h0E; end
            8:  begin r = a & b; e.fm = 'h0E; e.we = 0; end
            9:  begin r = b;     e.fm = 'h0E; end
            10: begin r = a;     e.fm = 'h0E; e.we = 0; end
            11: begin r = 0;     e.fm = 'h0F; end
            12: begin r = 255 - a; C = 1; e.fm = 'h0F; end
            13: begin r = (256 - a) & 255; V = (a == 128); C = (a != 0); e.fm = 'h0F; end
            14: begin r = (a + 1) & 255; V = (a == 127); e.fm = 'h0E; end
            15: begin r = (a + 255) & 255; V = (a == 128); e.fm = 'h0E; end
            16, 19: begin
                r = ((a * 2) & 255) | ((op == 19) ? c : 0);
                C = (a >= 128); V = ((r >= 128) ? 1 : 0) ^ C; e.fm = 'h0F;
            end
            17: begin r = (a / 2) | (a & 128); C = a % 2; e.fm = 'h0D; end
            18: begin r = a / 2; C = a % 2; e.fm = 'h0D; end
            20: begin r = (a / 2) + c * 128; C = a % 2; e.fm = 'h0D; end
            21: begin
                add = 0;
                if ((a % 16) > 9 || h != 0) add += 6;
                if ((a / 16) > 9 || c != 0 || ((a / 16) == 9 && (a % 16) > 9)) add += 96;
                s = a + add; r = s & 255; C = (c != 0 || s > 255); e.fm = 'h0D;
            end
            22: begin r = b; hi = (b >= 128) ? 255 : 0; e.fm = 'h0C; end
            23: begin p = a * b; r = p % 256; hi = p / 256; C = (p / 128) % 2; e.fm = 'h05; end
            default: begin r = 0; e.we = 0; end
        endcase
        e.res = r; e.hi = hi;
        e.fv  = H * 32 + ((r >= 128) ? 8 : 0) + ((r == 0) ? 4 : 0) + V * 2 + C;
        if (op == 22) e.fv = ((b >= 128) ? 8 : 0) + ((b == 0) ? 4 : 0);
        if (op == 23) e.fv = (((a * b) == 0) ? 4 : 0) + C;
        e.fv = e.fv & e.fm;
        e.tag = tag_of(op);
        return e;
    endfunction

    task automatic drive(int op, int a, int b, int c, int h, int cap);
        item_t e;
        @(posedge clk);
        #1;
        op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); c_i = c[0]; h_i = h[0]; cap_i = cap[0];
        e = model(op, a, b, c, h);
        e.cc = cc_model;
        sbq.push_back(e);
        if (cap != 0) cc_model = (cc_model & ~e.fm) | (e.fv & e.fm);
    endtask

    initial begin : monitor
        item_t e;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                if (e.we != 0) chk(e.tag, "result", int'(res_o), e.res);
                chk(e.tag, "high byte", int'(res_hi_o), e.hi);
                chk(e.tag, "write enable", int'(wr_o), e.we);
                chk(e.tag, "flag mask", int'(fmask_o), e.fm);
                chk(e.tag, "masked flags", int'(fval_o & fmask_o), e.fv);
                chk("R11", "condition register", int'(cc_o), e.cc);
            end
        end
    end

    function automatic int next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed & 32'h7FFF_FFFF;
    endfunction

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset value", int'(cc_o), 0);

        // R1 overflow and half-carry, wrap to zero, carry in
        drive(0, 'h7F, 'h01, 0, 0, 1);
        drive(0, 'hFF, 'h01, 0, 0, 1);
        drive(1, 'h0F, 'h00, 1, 0, 1);
        drive(1, 'h80, 'h80, 1, 0, 0);
        // R2 borrow, signed overflow, compare
        drive(2, 'h00, 'h01, 0, 0, 1);
        drive(2, 'h80, 'h01, 0, 0, 1);
        drive(3, 'h10, 'h0F, 1, 0, 1);
        drive(4, 'h42, 'h42, 0, 0, 1);
        // R3 logic: carry must survive a capture
        drive(12, 'h00, 'h00, 0, 0, 1);
        drive(5, 'hF0, 'h0F, 0, 0, 1);
        drive(6, 'h80, 'h01, 0, 0, 1);
        drive(7, 'hAA, 'hAA, 0, 0, 1);
        drive(8, 'hFF, 'h80, 0, 0, 1);
        drive(9, 'h11, 'h00, 0, 0, 1);
        drive(10, 'h90, 'h33, 0, 0, 1);
        // R4
        drive(11, 'h5A, 'h00, 0, 0, 1);
        drive(12, 'hFF, 'h00, 0, 0, 1);
        // R5
        drive(13, 'h80, 0, 0, 0, 1);
        drive(13, 'h00, 0, 0, 0, 1);
        drive(13, 'h01, 0, 0, 0, 1);
        drive(14, 'h7F, 0, 1, 0, 1);
        drive(14, 'hFF, 0, 0, 0, 1);
        drive(15, 'h80, 0, 0, 0, 1);
        drive(15, 'h00, 0, 0, 0, 1);
        // R6
        drive(16, 'h40, 0, 0, 0, 1);
        drive(16, 'hC0, 0, 0, 0, 1);
        drive(17, 'h81, 0, 0, 0, 1);
        drive(18, 'h81, 0, 0, 0, 1);
        drive(18, 'h01, 0, 0, 0, 1);
        // R7
        drive(19, 'h80, 0, 1, 0, 1);
        drive(19, 'h40, 0, 0, 0, 1);
        drive(20, 'h01, 0, 1, 0, 1);
        drive(20, 'h02, 0, 0, 0, 1);
        // R8 each correction path
        drive(21, 'h9A, 0, 0, 0, 1);
        drive(21, 'h15, 0, 0, 1, 1);
        drive(21, 'h23, 0, 1, 0, 1);
        drive(21, 'hA5, 0, 0, 0, 1);
        drive(21, 'h45, 0, 0, 0, 1);
        drive(21, 'h99, 0, 1, 1, 1);
        // R9
        drive(22, 0, 'h80, 0, 0, 1);
        drive(22, 0, 'h00, 0, 0, 1);
        drive(22, 0, 'h7F, 0, 0, 1);
        // R10
        drive(23, 'h10, 'h10, 0, 0, 1);
        drive(23, 'h0F, 'h0F, 0, 0, 1);
        drive(23, 'h00, 'h37, 0, 0, 1);
        drive(23, 'hFF, 'hFF, 0, 0, 1);
        // R11 strobe low must hold the register
        drive(11, 0, 0, 0, 0, 0);
        drive(12, 'h12, 0, 0, 0, 0);
        drive(0, 'h7F, 'h01, 0, 0, 1);
        // R12 unused codes
        drive(24, 'hFF, 'hFF, 1, 1, 1);
        drive(31, 'h01, 'h02, 1, 1, 1);
        for (int i = 0; i < 600; i++) begin
            int r1, r2;
            r1 = next_rand();
            r2 = next_rand();
            drive(r1 % 26, r2 & 255, (r2 >> 8) & 255, (r2 >> 16) & 1, (r2 >> 17) & 1, (r2 >> 18) & 1);
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule